// File: doc/BRIEF.md
# Dual-Rail Offset Address Adder

This combinational unit forms an effective address for a downstream decoder. It adds a small signed offset to an unsigned base address. Each operand arrives on two rails, the true bus and its bitwise complement. The result leaves on two rails as well, so the decoder can use either polarity without inverters of its own.

The true result comes from a ripple chain. A half-adder cell handles the low bit, and full-adder cells handle every bit above it. Before the add, the offset is sign-extended from its top bit to the full address width. The complement result comes from a second ripple chain, which runs only on the complement inputs and has a carry-in of one. Both chains are built from explicit cell instances, so the carry path can be traced cell by cell.

A rail check compares every true input bit with its complement partner. If any pair agrees, the error output goes high. The complement rails are then treated as untrusted, and both outputs are formed from the true inputs alone.

Top module: `addr_off_adder`

## Requirements
- R1: With consistent rails, `eff_t` equals (`rel_t` + sign-extended `off_t`) modulo 32, where `rel_t` is unsigned 0..31 and `off_t` is two's complement with bit 1 as the sign.
- R2: A negative offset below zero wraps to the top of the range, so 0 + (-2) gives 30 and 1 + (-2) gives 31.
- R3: A carry out of bit 4 is dropped: 31 + 1 gives 0, and no carry or overflow output exists.
- R4: `eff_c` is the exact bitwise inverse of `eff_t` for every input combination, including inconsistent rails.
- R5: `rail_err` is 1 exactly when some bit of `rel_t` equals the same bit of `rel_c`, or some bit of `off_t` equals the same bit of `off_c`; otherwise it is 0.
- R6: While `rail_err` is 1, `eff_t` depends only on `rel_t` and `off_t`; the values on `rel_c` and `off_c` have no effect on it.
- R7: `off_t` codes 2'b10 and 2'b11 mean -2 and -1, and codes 2'b00 and 2'b01 mean 0 and +1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rel_t | input | 5 | Relative address, true rail |
| rel_c | input | 5 | Relative address, complement rail |
| off_t | input | 2 | Signed offset, true rail |
| off_c | input | 2 | Signed offset, complement rail |
| eff_t | output | 5 | Effective address, true rail |
| eff_c | output | 5 | Effective address, complement rail |
| rail_err | output | 1 | Some input bit agrees with its complement partner |

## Verification
The bench applies every one of the 16384 combinations of the four input buses, so every corrupted-rail pattern is covered as well as every consistent one. Several cases get their own requirement tag. One is the full carry ripple at 31 + 1; a design that kept the carry, or broke the chain, would give a value other than 0. Another is the negative wrap from small bases; a design that zero-extended the offset would give 2 or 3 in place of 30 or 31. A third is any corrupted complement rail. A design that trusted that rail would return a complement result that is not the inverse of the true one, or would miss the error flag. Single-bit and multi-bit disagreements alike must set `rail_err`.

// File: rtl/addr_off_adder.sv
module addr_ha_cell (
  input  logic a,
  input  logic b,
  output logic s,
  output logic co
);
  assign s  = a ^ b;
  assign co = a & b;
endmodule

module addr_fa_cell (
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic s,
  output logic co
);
  assign s  = a ^ b ^ ci;
  assign co = (a & b) | (b & ci) | (a & ci);
endmodule

module addr_off_adder #(
  parameter int AW = 5,
  parameter int OW = 2
) (
  input  logic [AW-1:0] rel_t,
  input  logic [AW-1:0] rel_c,
  input  logic [OW-1:0] off_t,
  input  logic [OW-1:0] off_c,
  output logic [AW-1:0] eff_t,
  output logic [AW-1:0] eff_c,
  output logic          rail_err
);
  localparam int XW = AW - OW;

  logic [AW-1:0] opnd_t, opnd_c;
  logic [AW-1:0] sum_t, sum_c;
  logic [AW:0]   cy_t, cy_c;

  assign opnd_t = {{XW{off_t[OW-1]}}, off_t};
  assign opnd_c = {{XW{off_c[OW-1]}}, off_c};

  assign cy_t[0] = 1'b0;
  assign cy_c[0] = 1'b1;

  genvar i;
  generate
    for (i = 0; i < AW; i++) begin : g_bit
      if (i == 0) begin : g_lo
        addr_ha_cell u_ha_t (.a(rel_t[i]), .b(opnd_t[i]), .s(sum_t[i]), .co(cy_t[i+1]));
      end else begin : g_hi
        addr_fa_cell u_fa_t (.a(rel_t[i]), .b(opnd_t[i]), .ci(cy_t[i]), .s(sum_t[i]), .co(cy_t[i+1]));
      end
      addr_fa_cell u_fa_c (.a(rel_c[i]), .b(opnd_c[i]), .ci(cy_c[i]), .s(sum_c[i]), .co(cy_c[i+1]));
    end
  endgenerate

  assign rail_err = |(rel_t ~^ rel_c) | |(off_t ~^ off_c);
  assign eff_t    = sum_t;
  assign eff_c    = rail_err ? ~sum_t : sum_c;
endmodule

// File: rtl/addr_off_adder_chk.sv
module addr_off_adder_chk #(
  parameter int AW = 5,
  parameter int OW = 2
) (
  input logic [AW-1:0] rel_t,
  input logic [AW-1:0] rel_c,
  input logic [OW-1:0] off_t,
  input logic [OW-1:0] off_c,
  input logic [AW-1:0] eff_t,
  input logic [AW-1:0] eff_c,
  input logic          rail_err
);
  localparam int MOD = 1 << AW;

  function automatic int signed sval(input logic [OW-1:0] v);
    int signed r;
    r = int'(v);
    if (v[OW-1]) r = r - (1 << OW);
    return r;
  endfunction

  always_comb begin
    assert_sum_R1: assert (int'(eff_t) == ((int'(rel_t) + sval(off_t) + MOD) % MOD));
    assert_inverse_R4: assert ((eff_t ^ eff_c) == {AW{1'b1}});
    if (rel_c == ~rel_t && off_c == ~off_t)
      assert_clean_R5: assert (rail_err == 1'b0);
    else
      assert_flag_R5: assert (rail_err == 1'b1);
    if (rel_t == {AW{1'b1}} && off_t == OW'(1))
      assert_wrap_top_R3: assert (eff_t == '0);
  end
endmodule

bind addr_off_adder addr_off_adder_chk #(.AW(AW), .OW(OW)) u_chk (
  .rel_t(rel_t), .rel_c(rel_c), .off_t(off_t), .off_c(off_c),
  .eff_t(eff_t), .eff_c(eff_c), .rail_err(rail_err)
);

// File: tb/addr_off_adder_tb_top.sv
module addr_off_adder_tb_top;
  typedef struct {
    logic [4:0] rel;
    logic [1:0] off;
    logic [4:0] eff;
    logic       err;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4:0] rel_t = '0, rel_c = '1, eff_t, eff_c;
  logic [1:0] off_t = '0, off_c = '1;
  logic rail_err;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;
  exp_t sb[$];

  always #4 clk = ~clk;

  addr_off_adder dut_i (
    .rel_t(rel_t), .rel_c(rel_c), .off_t(off_t), .off_c(off_c),
    .eff_t(eff_t), .eff_c(eff_c), .rail_err(rail_err)
  );

  task automatic drive(input logic [4:0] rt, input logic [4:0] rc,
                       input logic [1:0] ot, input logic [1:0] oc);
    exp_t e;
    int sv;
    @(posedge clk);
    rel_t = rt; rel_c = rc; off_t = ot; off_c = oc;
    sv = ot[1] ? int'(ot) - 4 : int'(ot);
    e.rel = rt;
    e.off = ot;
    e.eff = 5'((int'(rt) + sv + 32) % 32);
    e.err = (rc != ~rt) || (oc != ~ot);
    sb.push_back(e);
  endtask

  always @(negedge clk) begin
    if (!rst && sb.size() > 0) begin
      exp_t e;
      string tag;
      e = sb.pop_front();
      n_chk++;
      if (e.err) tag = "R6";
      else if (e.rel == 5'd31 && e.off == 2'b01) tag = "R3";
      else if (e.off[1] && e.rel < 5'd2) tag = "R2";
      else if (e.off[1]) tag = "R7";
      else tag = "R1";
      if (eff_t !== e.eff) begin
        n_err++;
        $display("FAIL %s eff_t rel=%0d off=%b: got %0d expected %0d", tag, e.rel, e.off, eff_t, e.eff);
      end
      n_chk++;
      if (eff_c !== ~e.eff) begin
        n_err++;
        $display("FAIL R4 eff_c rel=%0d off=%b: got %b expected %b", e.rel, e.off, eff_c, ~e.eff);
      end
      n_chk++;
      if (rail_err !== e.err) begin
        n_err++;
        $display("FAIL R5 rail_err rel=%0d off=%b: got %b expected %b", e.rel, e.off, rail_err, e.err);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // Reset-time input pattern: zero base, zero offset, clean rails (R1)
    drive(5'd0, 5'h1f, 2'b00, 2'b11);
    // Named corners first: R3 full ripple, R2 negative wrap
    drive(5'd31, 5'd0, 2'b01, 2'b10);
    drive(5'd0, 5'h1f, 2'b10, 2'b01);
    drive(5'd1, 5'h1e, 2'b10, 2'b01);
    // Exhaustive sweep of all four buses (R1, R4, R5, R6, R7)
    for (int a = 0; a < 32; a++)
      for (int ac = 0; ac < 32; ac++)
        for (int o = 0; o < 4; o++)
          for (int oc = 0; oc < 4; oc++)
            drive(5'(a), 5'(ac), 2'(o), 2'(oc));
    @(posedge clk);
    @(negedge clk);
    @(posedge clk);
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule